// File: doc/BRIEF.md
# Shared-Bus Flash/SRAM Select Arbiter

This block stands between a single host request port and a memory package in which a NOR flash and an asynchronous SRAM share one address bus and one 16-bit data bus. Each accepted request names its target memory. The block turns that request into the select, output-enable, write-enable and byte-enable pattern the target needs, and places the address on the bus. It keeps the other memory fully deselected the whole time.

The flash sees an active-low chip enable. The SRAM is selected only when its active-low enable is low and its active-high enable is high. The block never drives the flash enable and the SRAM pair active in the same cycle. When consecutive accesses go to different memories, the block holds both memories deselected for a programmable number of clocks, so the device leaving the bus can release it.

A static configuration strap puts the flash into 8-bit mode. In that mode, data pin 15 carries the extra low-order address bit and pins 14:8 are never driven. The SRAM is always 16 bits wide, and its byte accesses are steered to one lane through the two byte enables. Each access holds its bus pattern for a fixed number of clocks and then returns a one-cycle response.

Top module: `shmem_sel`

## Requirements
- R1: In no cycle are `flash_ce_n`=0, `sram_ce1_n`=0 and `sram_ce2`=1 at the same time.
- R2: After reset, and whenever no access is in progress, every memory is deselected: `flash_ce_n`=1, `sram_ce1_n`=1, `sram_ce2`=0, both byte enables are 1, both output enables are 1, `mem_we_n`=1 and `dq_oe`=0.
- R3: If the previous access went to the other memory, `TURN_CYC` fully deselected cycles follow the accept cycle before the access begins. If it went to the same memory, or if this is the first access after reset, the access begins in the cycle after the accept.
- R4: `req_ready` is 1 only when no access is in progress. An access holds its bus pattern for exactly `ACC_CYC` cycles. `rsp_valid` is then high for one cycle, and `req_ready` is high again in that same cycle.
- R5: For a flash access, `mem_addr` equals `req_addr[21:1]`, and `flash_word_sel` equals the inverse of `flash_byte_mode`.
- R6: With `flash_byte_mode`=1, every flash access drives `dq_out[15]`=`req_addr[0]` with `dq_oe[15]`=1 and never drives pins 14:8. Read data then returns the low lane in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]`=0.
- R7: For an SRAM access, `mem_addr[17:0]` equals `req_addr[18:1]` and `mem_addr[20:18]` is 0.
- R8: For an SRAM access, a byte request with `req_addr[0]`=0 asserts only `sram_lb_n` (lane 7:0). A byte request with `req_addr[0]`=1 asserts only `sram_ub_n` (lane 15:8). A word request asserts both. A byte read returns the selected lane in `rsp_rdata[7:0]` with the upper byte 0.
- R9: A flash read drives `flash_oe_n`=0 and `sram_oe_n`=1. An SRAM read drives `sram_oe_n`=0 and `flash_oe_n`=1. A write holds both output enables at 1 and drives `mem_we_n`=0.
- R10: On a write, `dq_oe` covers exactly the enabled lanes. A byte write puts `req_wdata[7:0]` on the lane it selects. A read drives no data pin, apart from the flash address pin of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_tgt | input | 1 | Target: 0 flash, 1 SRAM |
| req_byte | input | 1 | 1 for a byte access (SRAM), 0 for a word |
| req_wr | input | 1 | 1 write, 0 read |
| req_addr | input | 22 | Host byte address |
| req_wdata | input | 16 | Write data |
| flash_byte_mode | input | 1 | Static strap: flash bus is 8 bits wide |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| mem_addr | output | 21 | Shared memory address bus |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-pin data bus drive enable |
| dq_in | input | 16 | Data bus input value |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_word_sel | output | 1 | Flash width select, 1 for 16-bit |
| sram_ce1_n | output | 1 | SRAM enable, active low |
| sram_ce2 | output | 1 | SRAM enable, active high |
| sram_ub_n | output | 1 | SRAM upper byte enable, active low |
| sram_lb_n | output | 1 | SRAM lower byte enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| mem_we_n | output | 1 | Shared write enable, active low |

## Verification
Several behaviours are checked in every cycle:
- the forbidden three-enable combination never appears;
- a change of target never follows fewer than `TURN_CYC` idle cycles;
- the SRAM output enable never goes low while the flash is selected;
- pins 14:8 stay undriven during flash byte-mode accesses;
- the ready/response handshake follows its ordering.

Other behaviours can only be shown by the bench's scenarios, because they depend on what was requested:
- the exact gap length;
- the address remapping for each target;
- which SRAM lane a byte access picks;
- how byte reads are shifted into the low byte;
- the drive pattern of write data.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

    localparam int LANE_W = 8;
    localparam int NLANE  = 2;
    localparam int DATA_W = LANE_W * NLANE;

    typedef enum logic {
        TGT_FLASH = 1'b0,
        TGT_SRAM  = 1'b1
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GAP    = 2'd1,
        ST_ACCESS = 2'd2
    } st_e;

    typedef struct packed {
        tgt_e tgt;
        logic is_byte;
        logic is_wr;
    } ctl_t;

    typedef struct packed {
        logic fl_ce_n;
        logic sr_ce1_n;
        logic sr_ce2;
        logic sr_ub_n;
        logic sr_lb_n;
        logic fl_oe_n;
        logic sr_oe_n;
        logic we_n;
    } pins_t;

    function automatic pins_t pins_idle();
        pins_t p;
        p = '{fl_ce_n: 1'b1, sr_ce1_n: 1'b1, sr_ce2: 1'b0, sr_ub_n: 1'b1,
              sr_lb_n: 1'b1, fl_oe_n: 1'b1, sr_oe_n: 1'b1, we_n: 1'b1};
        return p;
    endfunction

    // Lanes a request touches: bit 0 is data 7:0, bit 1 is data 15:8.
    function automatic logic [NLANE-1:0] lanes_of(input ctl_t c, input logic fl_byte,
                                                  input logic a0);
        if (c.tgt == TGT_FLASH)
            return fl_byte ? 2'b01 : 2'b11;
        else if (c.is_byte)
            return a0 ? 2'b10 : 2'b01;
        else
            return 2'b11;
    endfunction

endpackage

// File: rtl/shmem_seq.sv
module shmem_seq
    import shmem_pkg::*;
#(
    parameter int ACC_CYC  = 3,
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  tgt_e req_tgt,
    output logic ready,
    output logic active,
    output logic done
);
    localparam int CMAX = (ACC_CYC > TURN_CYC) ? ACC_CYC : TURN_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] ACC_LAST  = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] TURN_LAST = CW'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

    st_e            state;
    logic [CW-1:0]  cnt;
    tgt_e           last_tgt;
    logic           last_vld;
    logic           accept;
    logic           need_gap;

    assign ready    = (state == ST_IDLE);
    assign active   = (state == ST_ACCESS);
    assign done     = active && (cnt == ACC_LAST);
    assign accept   = req_valid && ready;
    assign need_gap = last_vld && (req_tgt != last_tgt) && (TURN_CYC > 0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            last_tgt <= TGT_FLASH;
            last_vld <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    last_tgt <= req_tgt;
                    last_vld <= 1'b1;
                    cnt      <= '0;
                    state    <= need_gap ? ST_GAP : ST_ACCESS;
                end
                ST_GAP: begin
                    if (cnt == TURN_LAST) begin
                        cnt   <= '0;
                        state <= ST_ACCESS;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ACCESS: begin
                    if (cnt == ACC_LAST) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);
    // R4
    done_frees_port_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);

endmodule

// File: rtl/shmem_decode.sv
module shmem_decode
    import shmem_pkg::*;
#(
    parameter int FL_AW = 21,
    parameter int SR_AW = 18
) (
    input  logic              active,
    input  ctl_t              ctl,
    input  logic              fl_byte,
    input  logic [FL_AW:0]    addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_in,
    output pins_t             pins,
    output logic [FL_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe,
    output logic [DATA_W-1:0] rd_data
);
    logic [NLANE-1:0]  lane_en;
    logic              byte_acc;
    logic [DATA_W-1:0] lane_dq;
    logic [DATA_W-1:0] lane_oe;

    assign lane_en  = lanes_of(ctl, fl_byte, addr[0]);
    assign byte_acc = (ctl.tgt == TGT_FLASH) ? fl_byte : ctl.is_byte;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_dq[g*LANE_W +: LANE_W] = byte_acc ? wdata[LANE_W-1:0]
                                                      : wdata[g*LANE_W +: LANE_W];
        assign lane_oe[g*LANE_W +: LANE_W] = {LANE_W{active & ctl.is_wr & lane_en[g]}};
    end

    always_comb begin
        pins   = pins_idle();
        dq_out = lane_dq;
        dq_oe  = lane_oe;
        if (active) begin
            if (ctl.tgt == TGT_FLASH) begin
                pins.fl_ce_n = 1'b0;
                pins.fl_oe_n = ctl.is_wr;
                if (fl_byte) begin
                    dq_out[DATA_W-1] = addr[0];
                    dq_oe[DATA_W-1]  = 1'b1;
                end
            end else begin
                pins.sr_ce1_n = 1'b0;
                pins.sr_ce2   = 1'b1;
                pins.sr_ub_n  = !lane_en[1];
                pins.sr_lb_n  = !lane_en[0];
                pins.sr_oe_n  = ctl.is_wr;
            end
            pins.we_n = !ctl.is_wr;
        end
    end

    always_comb begin
        if (ctl.tgt == TGT_FLASH)
            mem_addr = addr[FL_AW:1];
        else
            mem_addr = {{(FL_AW-SR_AW){1'b0}}, addr[SR_AW:1]};
    end

    always_comb begin
        if (!byte_acc)
            rd_data = dq_in;
        else if (ctl.tgt == TGT_SRAM && addr[0])
            rd_data = {{LANE_W{1'b0}}, dq_in[DATA_W-1:LANE_W]};
        else
            rd_data = {{LANE_W{1'b0}}, dq_in[LANE_W-1:0]};
    end

endmodule

// File: rtl/shmem_sel.sv
module shmem_sel
    import shmem_pkg::*;
#(
    parameter int FL_AW    = 21,
    parameter int SR_AW    = 18,
    parameter int ACC_CYC  = 3,
    parameter int TURN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_tgt,
    input  logic              req_byte,
    input  logic              req_wr,
    input  logic [FL_AW:0]    req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              flash_byte_mode,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [FL_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_word_sel,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic              sram_oe_n,
    output logic              mem_we_n
);
    localparam int IW = $clog2(TURN_CYC + 2);

    ctl_t              ctl_q;
    logic [FL_AW:0]    addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              active;
    logic              done;
    pins_t             pins;
    logic [DATA_W-1:0] rd_data;

    shmem_seq #(.ACC_CYC(ACC_CYC), .TURN_CYC(TURN_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_tgt   (tgt_e'(req_tgt)),
        .ready     (req_ready),
        .active    (active),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '{tgt: TGT_FLASH, is_byte: 1'b0, is_wr: 1'b0};
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_valid && req_ready) begin
            ctl_q   <= '{tgt: tgt_e'(req_tgt), is_byte: req_byte, is_wr: req_wr};
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    shmem_decode #(.FL_AW(FL_AW), .SR_AW(SR_AW)) u_dec (
        .active   (active),
        .ctl      (ctl_q),
        .fl_byte  (flash_byte_mode),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .dq_in    (dq_in),
        .pins     (pins),
        .mem_addr (mem_addr),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= done;
            if (done)
                rsp_rdata <= ctl_q.is_wr ? '0 : rd_data;
        end
    end

    assign flash_ce_n     = pins.fl_ce_n;
    assign flash_oe_n     = pins.fl_oe_n;
    assign sram_ce1_n     = pins.sr_ce1_n;
    assign sram_ce2       = pins.sr_ce2;
    assign sram_ub_n      = pins.sr_ub_n;
    assign sram_lb_n      = pins.sr_lb_n;
    assign sram_oe_n      = pins.sr_oe_n;
    assign mem_we_n       = pins.we_n;
    assign flash_word_sel = !flash_byte_mode;

    // Bus ownership monitor for the turnaround property
    logic          fl_on, sr_on, seen_q, prev_sr_q;
    logic [IW-1:0] idle_q;
    assign fl_on = !flash_ce_n;
    assign sr_on = !sram_ce1_n && sram_ce2;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q    <= 1'b0;
            prev_sr_q <= 1'b0;
            idle_q    <= '0;
        end else if (fl_on || sr_on) begin
            seen_q    <= 1'b1;
            prev_sr_q <= sr_on;
            idle_q    <= '0;
        end else if (idle_q < IW'(TURN_CYC)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R1
    no_dual_select_chk: assert property (@(posedge clk) disable iff (rst)
        !(!flash_ce_n && !sram_ce1_n && sram_ce2));
    // R3
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && (fl_on || sr_on) && (sr_on != prev_sr_q)) |-> (idle_q >= IW'(TURN_CYC)));
    // R9
    sram_oe_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> flash_ce_n);
    // R6
    flash_upper_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_on && flash_byte_mode) |-> (dq_oe[DATA_W-2:LANE_W] == '0));
    // R4
    rsp_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

endmodule

// File: tb/shmem_sel_tb.sv
module shmem_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_CYC    = 3;
    localparam int TURN_CYC   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_tgt = 1'b0, req_byte = 1'b0, req_wr = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        fbm = 1'b0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata, dq_out, dq_oe, dq_in;
    logic [20:0] mem_addr;
    logic        flash_ce_n, flash_oe_n, flash_word_sel, sram_ce1_n, sram_ce2;
    logic        sram_ub_n, sram_lb_n, sram_oe_n, mem_we_n;

    int n_chk = 0, n_fail = 0;
    bit have_last = 0, last_tgt = 0, finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shmem_sel #(.ACC_CYC(ACC_CYC), .TURN_CYC(TURN_CYC)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_tgt(req_tgt), .req_byte(req_byte), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .flash_byte_mode(fbm), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe),
        .dq_in(dq_in), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
        .flash_word_sel(flash_word_sel), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
        .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_oe_n(sram_oe_n),
        .mem_we_n(mem_we_n)
    );

    // Memory model: a fixed word per address; flash byte mode picks a lane by pin 15.
    function automatic logic [15:0] mword(input logic [20:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ {3'b000, a[20:16]} ^ 8'h3C};
    endfunction

    wire [15:0] fw = mword(mem_addr);
    assign dq_in = (!flash_ce_n && fbm) ? {8'hEE, (dq_out[15] ? fw[15:8] : fw[7:0])} : fw;

    wire [7:0] pins_now = {flash_ce_n, sram_ce1_n, sram_ce2, sram_ub_n, sram_lb_n,
                           flash_oe_n, sram_oe_n, mem_we_n};

    function automatic logic [1:0] e_lanes(input bit t, input bit b, input bit a0);
        if (!t) return fbm ? 2'b01 : 2'b11;
        return b ? (a0 ? 2'b10 : 2'b01) : 2'b11;
    endfunction

    function automatic logic [7:0] e_pins(input bit t, input bit b, input bit w, input bit a0);
        logic [1:0] ln = e_lanes(t, b, a0);
        if (!t) return {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, w, 1'b1, !w};
        return {1'b1, 1'b0, 1'b1, !ln[1], !ln[0], 1'b1, w, !w};
    endfunction

    function automatic logic [20:0] e_addr(input bit t, input logic [21:0] a);
        return t ? {3'b000, a[18:1]} : a[21:1];
    endfunction

    function automatic logic [15:0] e_oe(input bit t, input bit b, input bit w, input bit a0);
        logic [1:0]  ln = e_lanes(t, b, a0);
        logic [15:0] m  = w ? {{8{ln[1]}}, {8{ln[0]}}} : 16'h0000;
        if (!t && fbm) m[15] = 1'b1;
        return m;
    endfunction

    function automatic logic [15:0] e_out(input bit t, input bit b, input logic [21:0] a,
                                          input logic [15:0] wd);
        logic [15:0] v = ((t && b) || (!t && fbm)) ? {wd[7:0], wd[7:0]} : wd;
        if (!t && fbm) v[15] = a[0];
        return v;
    endfunction

    function automatic logic [15:0] e_rd(input bit t, input bit b, input bit w,
                                         input logic [21:0] a);
        logic [15:0] m = mword(e_addr(t, a));
        if (w) return 16'h0000;
        if ((t && b) || (!t && fbm)) return {8'h00, (a[0] ? m[15:8] : m[7:0])};
        return m;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(pins_now == 8'b11011111, tag, {24'd0, pins_now}, 32'hDF);
        chk(dq_oe == 16'h0000, tag, {16'd0, dq_oe}, 32'h0);
    endtask

    // Called at a falling edge with the block idle.
    task automatic xact(input bit t, input bit b, input bit w, input logic [21:0] a,
                        input logic [15:0] wd);
        int gap = 0;
        int exp_gap = (have_last && (t != last_tgt)) ? TURN_CYC : 0;
        logic [15:0] eo = e_oe(t, b, w, a[0]);
        chk(req_ready == 1'b1, "R4 ready while idle", {31'd0, req_ready}, 32'd1);
        req_tgt = t; req_byte = b; req_wr = w; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (flash_ce_n && !(!sram_ce1_n && sram_ce2) && gap < 40) begin
            chk_idle("R2/R3 gap deselected");
            gap++;
            @(negedge clk);
        end
        chk(gap == exp_gap, "R3 turnaround length", gap, exp_gap);
        for (int i = 0; i < ACC_CYC; i++) begin
            chk(pins_now == e_pins(t, b, w, a[0]), "R8/R9 control pins",
                {24'd0, pins_now}, {24'd0, e_pins(t, b, w, a[0])});
            chk(mem_addr == e_addr(t, a), t ? "R7 sram address" : "R5 flash address",
                {11'd0, mem_addr}, {11'd0, e_addr(t, a)});
            chk(dq_oe == eo, "R10/R6 drive enables", {16'd0, dq_oe}, {16'd0, eo});
            chk((dq_out & dq_oe) == (e_out(t, b, a, wd) & eo), "R10/R6 drive data",
                {16'd0, dq_out & dq_oe}, {16'd0, e_out(t, b, a, wd) & eo});
            chk(!req_ready && !rsp_valid, "R4 busy during access",
                {30'd0, req_ready, rsp_valid}, 32'd0);
            @(negedge clk);
        end
        chk(rsp_valid && req_ready, "R4 response pulse", {30'd0, rsp_valid, req_ready}, 32'd3);
        chk(rsp_rdata == e_rd(t, b, w, a), "R6/R8 read data",
            {16'd0, rsp_rdata}, {16'd0, e_rd(t, b, w, a)});
        chk_idle("R2 idle after access");
        have_last = 1; last_tgt = t;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R2 reset state");
        chk(req_ready && !rsp_valid, "R2 reset handshake", {30'd0, req_ready, rsp_valid}, 32'd2);
        chk(flash_word_sel == 1'b1, "R5 word select", {31'd0, flash_word_sel}, 32'd1);
        // Directed corners
        xact(1'b0, 1'b0, 1'b0, 22'h2ABCDE, 16'h0000);  // first access: no gap (R3)
        xact(1'b0, 1'b0, 1'b1, 22'h155554, 16'hBEEF);  // same target: no gap
        xact(1'b1, 1'b1, 1'b0, 22'h3FFFFF, 16'h0000);  // switch, SRAM upper lane read (R8)
        xact(1'b1, 1'b1, 1'b0, 22'h000002, 16'h0000);  // SRAM lower lane read
        xact(1'b1, 1'b1, 1'b1, 22'h012345, 16'h00A7);  // SRAM upper lane write (R10)
        xact(1'b1, 1'b0, 1'b1, 22'h07FFFE, 16'h1234);  // SRAM word write
        fbm = 1'b1;
        @(negedge clk);
        chk(flash_word_sel == 1'b0, "R5 byte-mode select", {31'd0, flash_word_sel}, 32'd0);
        xact(1'b0, 1'b0, 1'b0, 22'h000001, 16'h0000);  // flash byte mode, high byte (R6)
        xact(1'b0, 1'b1, 1'b0, 22'h1F0000, 16'h0000);  // flash byte mode, low byte
        xact(1'b0, 1'b0, 1'b1, 22'h2A0003, 16'hFF5C);  // flash byte mode write
        fbm = 1'b0;
        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int idle = $urandom_range(0, 2);
            if ($urandom_range(0, 19) == 0) fbm = $urandom_range(0, 1) != 0;
            repeat (idle) begin
                @(negedge clk);
                chk_idle("R2 host idle");
            end
            xact($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
                 $urandom_range(0, 1) != 0, 22'($urandom), 16'($urandom));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R4 actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule